// File: doc/BRIEF.md
# Error-to-Absolute Voltage Reconstruction

This block follows a front-end error converter. The converter delivers the difference between a programmed reference and a sensed voltage as a signed code. The block turns each such sample back into an absolute voltage code in the reference DAC's own units. Downstream threshold logic, such as over-voltage or under-voltage detectors, can then compare that code directly against a fixed limit.

The error and reference codes use different step sizes. The error code has 1 mV steps and the DAC code has 1.5625 mV steps, so the two codes cannot simply be added. The block works in three steps:

- It limits the error to the range the converter can really produce at the programmed front-end gain.
- It rescales the limited error by 16/25 (0.64), rounding to the nearest integer.
- It subtracts the rescaled error from the DAC code and limits the result to the 10-bit output range.

Flags report when the raw error lay outside the range allowed at the current gain. All results appear one clock after the sample strobe, together with a valid pulse.

Top module: `err_abs_recon`

## Requirements
- R1: `gain_sel` encodes the front-end gain as 0=1, 1=2, 2=4 and 3=8. The error is limited to the range from −(256/gain) to +(248/gain). The limits are therefore −256..248, −128..124, −64..62 and −32..31.
- R2: When a strobed raw error is greater than the upper limit, `sat_pos` is 1 and `err_clamped` equals the upper limit.
- R3: When a strobed raw error is less than the lower limit, `sat_neg` is 1 and `err_clamped` equals the lower limit. `sat_pos` and `sat_neg` are never 1 together.
- R4: A raw error inside the limits, including one exactly on a limit, passes to `err_clamped` unchanged. In that case both flags are 0.
- R5: `abs_code` equals `dac_code` minus round(`err_clamped`×16/25), rounded to the nearest integer. For example, DAC 747 gives 624 for error 192, 588 for error 248 and 911 for error −256.
- R6: If that difference is below 0, `abs_code` is 0. If it is above 1023, `abs_code` is 1023.
- R7: The results appear on the clock edge after a cycle with `smp_vld`=1, and `res_vld` is 1 in exactly that cycle. After a cycle without the strobe, `res_vld` is 0.
- R8: After a cycle with `smp_vld`=0, `abs_code`, `err_clamped`, `sat_pos` and `sat_neg` keep their previous values, whatever the other inputs do.
- R9: While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Strobe: a new error sample is present |
| err_raw | input | 9 | Raw error, two's complement, 1 mV per step |
| gain_sel | input | 2 | Front-end gain code (0..3 selects 1, 2, 4, 8) |
| dac_code | input | 10 | Reference DAC code, unsigned, 1.5625 mV per step |
| res_vld | output | 1 | Result valid, one cycle after the strobe |
| abs_code | output | 10 | Reconstructed absolute voltage, DAC units |
| err_clamped | output | 9 | Error after the gain-dependent limit |
| sat_pos | output | 1 | Raw error was above the upper limit |
| sat_neg | output | 1 | Raw error was below the lower limit |

## Verification
The assertions check the following on every cycle:

- the one-cycle valid timing;
- holding of the outputs between strobes;
- mutual exclusion of the two flags;
- that the limited error always lies within the limits of the gain that was sampled;
- unchanged pass-through and the correct flag on each side of the range.

The 16/25 rounding, the output saturation at 0 and 1023, and the worked examples on the reference values are shown only by the bench's vectors. Each of these vectors has a hand-derived absolute code. The bench also covers reset behaviour in the middle of operation.

// File: rtl/err_abs_recon.sv
module err_abs_recon (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_vld,
  input  logic [8:0] err_raw,
  input  logic [1:0] gain_sel,
  input  logic [9:0] dac_code,
  output logic       res_vld,
  output logic [9:0] abs_code,
  output logic [8:0] err_clamped,
  output logic       sat_pos,
  output logic       sat_neg
);

  localparam logic signed [8:0] HI_BASE = 9'sd248;
  localparam logic signed [8:0] LO_BASE = 9'h100;

  logic signed [8:0]  err_s, lim_hi, lim_lo, err_c;
  logic               hi_hit, lo_hit;
  logic [8:0]         mag;
  logic [12:0]        num, quo;
  logic signed [13:0] base, delta, diff;
  logic [9:0]         abs_n;

  assign err_s  = signed'(err_raw);
  assign lim_hi = HI_BASE >>> gain_sel;
  assign lim_lo = LO_BASE >>> gain_sel;
  assign hi_hit = err_s > lim_hi;
  assign lo_hit = err_s < lim_lo;
  assign err_c  = hi_hit ? lim_hi : (lo_hit ? lim_lo : err_s);

  assign mag   = err_c[8] ? 9'(-err_c) : err_c;
  assign num   = {mag, 4'b0000} + 13'd12;
  assign quo   = num / 13'd25;
  assign base  = signed'({4'b0000, dac_code});
  assign delta = signed'({1'b0, quo});
  assign diff  = err_c[8] ? base + delta : base - delta;

  always_comb begin
    if (diff < 14'sd0)         abs_n = 10'd0;
    else if (diff > 14'sd1023) abs_n = 10'd1023;
    else                       abs_n = diff[9:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld     <= 1'b0;
      abs_code    <= '0;
      err_clamped <= '0;
      sat_pos     <= 1'b0;
      sat_neg     <= 1'b0;
    end else begin
      res_vld <= smp_vld;
      if (smp_vld) begin
        abs_code    <= abs_n;
        err_clamped <= err_c;
        sat_pos     <= hi_hit;
        sat_neg     <= lo_hit;
      end
    end
  end

endmodule

// File: rtl/err_abs_recon_chk.sv
module err_abs_recon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_vld,
  input logic [8:0] err_raw,
  input logic [1:0] gain_sel,
  input logic       res_vld,
  input logic [9:0] abs_code,
  input logic [8:0] err_clamped,
  input logic       sat_pos,
  input logic       sat_neg
);

  int raw_i, clp_i, hi_i, lo_i;
  assign raw_i = int'($signed(err_raw));
  assign clp_i = int'($signed(err_clamped));
  assign hi_i  = 248 >>> gain_sel;
  assign lo_i  = -(256 >>> gain_sel);

  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> res_vld);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !res_vld);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(abs_code) && $stable(err_clamped) && $stable(sat_pos) && $stable(sat_neg));

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat_pos && sat_neg));

  p_clamp_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> (clp_i <= (248 >>> $past(gain_sel))) && (clp_i >= -(256 >>> $past(gain_sel))));

  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && raw_i <= hi_i && raw_i >= lo_i |=> err_clamped == $past(err_raw) && !sat_pos && !sat_neg);

  p_pos_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && raw_i > hi_i |=> sat_pos && clp_i == (248 >>> $past(gain_sel)));

  p_neg_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && raw_i < lo_i |=> sat_neg && clp_i == -(256 >>> $past(gain_sel)));

endmodule

bind err_abs_recon err_abs_recon_chk u_chk (.*);

// File: tb/err_abs_recon_test.sv
module err_abs_recon_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_vld = 1'b0;
  logic [8:0] err_raw = '0;
  logic [1:0] gain_sel = '0;
  logic [9:0] dac_code = '0;
  logic       res_vld;
  logic [9:0] abs_code;
  logic [8:0] err_clamped;
  logic       sat_pos, sat_neg;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  err_abs_recon uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .err_raw(err_raw),
    .gain_sel(gain_sel), .dac_code(dac_code), .res_vld(res_vld),
    .abs_code(abs_code), .err_clamped(err_clamped),
    .sat_pos(sat_pos), .sat_neg(sat_neg)
  );

  localparam int NV = 17;
  localparam int V_G[NV]   = '{0, 0, 0, 3, 3, 1, 1, 2, 0, 0, 2, 0, 0, 0, 3, 3, 0};
  localparam int V_E[NV]   = '{192, 255, -256, 100, -100, 124, 125, -65, 200, -200, 62, -1, 1, 3, 31, -32, 0};
  localparam int V_D[NV]   = '{747, 747, 747, 747, 747, 500, 500, 10, 50, 1000, 0, 300, 300, 300, 747, 747, 1023};
  localparam int V_A[NV]   = '{624, 588, 911, 727, 767, 421, 421, 51, 0, 1023, 0, 301, 299, 298, 727, 767, 1023};
  localparam int V_C[NV]   = '{192, 248, -256, 31, -32, 124, 124, -64, 200, -200, 62, -1, 1, 3, 31, -32, 0};
  localparam int V_P[NV]   = '{0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_N[NV]   = '{0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int g, input int e, input int d);
    @(negedge clk);
    gain_sel = 2'(g);
    err_raw  = 9'(e);
    dac_code = 10'(d);
    smp_vld  = 1'b1;
    @(negedge clk);
    smp_vld  = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 res_vld in reset", int'(res_vld), 0);
    chk("R9 abs_code in reset", int'(abs_code), 0);
    chk("R9 err_clamped in reset", int'(err_clamped), 0);
    chk("R9 flags in reset", int'({sat_pos, sat_neg}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 no valid without strobe", int'(res_vld), 0);

    for (int i = 0; i < NV; i++) begin
      apply(V_G[i], V_E[i], V_D[i]);
      chk("R7 res_vld one cycle after strobe", int'(res_vld), 1);
      chk("R5 R6 abs_code", int'(abs_code), V_A[i]);
      chk("R1 R4 err_clamped", int'($signed(err_clamped)), V_C[i]);
      chk("R2 sat_pos", int'(sat_pos), V_P[i]);
      chk("R3 sat_neg", int'(sat_neg), V_N[i]);
    end

    apply(3, -100, 747);
    err_raw  = 9'(150);
    dac_code = 10'd5;
    gain_sel = 2'd0;
    @(negedge clk);
    chk("R7 res_vld drops", int'(res_vld), 0);
    chk("R8 abs_code held", int'(abs_code), 767);
    chk("R8 err_clamped held", int'($signed(err_clamped)), -32);
    chk("R8 sat_neg held", int'(sat_neg), 1);
    chk("R8 sat_pos held", int'(sat_pos), 0);

    @(negedge clk);
    gain_sel = 2'd1; err_raw = 9'(-129); dac_code = 10'd600; smp_vld = 1'b1;
    @(negedge clk);
    gain_sel = 2'd0; err_raw = 9'(16); dac_code = 10'd600;
    chk("R3 first of back-to-back", int'($signed(err_clamped)), -128);
    chk("R5 first of back-to-back", int'(abs_code), 682);
    @(negedge clk);
    smp_vld = 1'b0;
    chk("R7 second of back-to-back valid", int'(res_vld), 1);
    chk("R5 second of back-to-back", int'(abs_code), 590);
    chk("R3 neg flag cleared", int'(sat_neg), 0);

    apply(0, 255, 747);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears abs_code", int'(abs_code), 0);
    chk("R9 reset clears sat_pos", int'(sat_pos), 0);
    chk("R9 reset clears res_vld", int'(res_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule